// File: doc/BRIEF.md
# Serial-Loaded Converter Code Register

This block is the digital input side of a current-output data converter. A host drives three wires: an active-low select, a serial clock and a serial data line. While select is low, each rising serial clock moves one data bit into an internal shift register, most significant bit first. When select returns high, the shift register is copied into the parallel code register that feeds the converter. A one-cycle strobe marks each copy.

The three wires are asynchronous to the block's system clock. Each wire passes through a two-flop synchroniser, and its edges are detected in the system domain. The system clock must run at least four times faster than the serial clock. The serial clock must stay still while select is rising. The code width `CODE_W` is 16 or 14. A longer frame is accepted, and only the final `CODE_W` bits are kept. A 14-bit instance can therefore take the 16-bit frames that hosts which send two bytes produce.

Top module: `sdf_frontend`

## Requirements
- R1: While select is low, each rising serial clock shifts the data bit into the shift register LSB and moves older bits toward the MSB, so the word is sent MSB first.
- R2: While select is high, serial clock edges leave the shift register unchanged.
- R3: On each rising edge of select, the shift register is copied to `dac_code`. The new value appears on the third system clock edge after the select edge reaches the pin.
- R4: A frame longer than `CODE_W` bits keeps only the last `CODE_W` bits sent. The earlier bits are dropped.
- R5: With `CODE_W`=14, a 16-bit frame sets `dac_code` to its last 14 bits. The first two bits are dropped.
- R6: `code_load` is high for exactly one system clock for each select rising edge. This includes frames shorter than `CODE_W` bits and frames with no bits. In those cases `dac_code` takes whatever the shift register holds, which is the old contents shifted left by the bits received.
- R7: After reset, `dac_code` is zero, `code_load` is low, and the shift register is cleared. An empty frame sent after reset therefore loads zero.
- R8: `dac_code` changes only in the cycle where `code_load` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n_pin | input | 1 | Asynchronous active-low frame select |
| sclk_pin | input | 1 | Asynchronous serial clock, data taken on rising edge |
| sdata_pin | input | 1 | Asynchronous serial data, MSB first |
| dac_code | output | CODE_W | Parallel converter code register |
| code_load | output | 1 | One-cycle pulse when `dac_code` is loaded |

## Verification
Every fault inside the block ends up in `dac_code` or in the count of `code_load` pulses. The fault shows on the third system clock edge after the select rise that closes the frame. A lost, repeated or misordered bit shows up as a wrong code at the end of that frame. A shift while select is high stays hidden until an empty frame exposes the shift register contents. The synchroniser latency is fixed, so one sample point per frame is enough to pin down the output.

// File: rtl/sdf_pkg.sv
// Package: shared pin indices and reset levels for the serial code front end.
// Assumes the three external wires are bundled into one vector in pin order.
package sdf_pkg;
    localparam int PIN_CNT   = 3;
    localparam int PIN_SDATA = 0;
    localparam int PIN_SCLK  = 1;
    localparam int PIN_SEL   = 2;
    // Idle levels: select deasserted (high), clock low, data low
    localparam logic [PIN_CNT-1:0] PIN_IDLE = 3'b100;
endpackage

// File: rtl/sdf_sync.sv
// Module: multi-stage synchroniser bank, one chain per input bit.
// Assumes each bit is an independent slow level; no bus coherence is implied.
module sdf_sync #(
    parameter int              W       = 3,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw pins
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= RST_VAL;
                    else        stage_q[0] <= d_async;
                end
            end else begin : g_next
                // Pass the level one stage further
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/sdf_edge.sv
// Module: rising-edge detector for synchronised levels.
// Assumes inputs are already in the clk domain; output is combinational.
module sdf_edge #(
    parameter int           W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    // Remember last cycle's level
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= level;
    end

    // Flag a low-to-high change
    always_comb rise = level & ~prev_q;
endmodule

// File: rtl/sdf_capture.sv
// Module: serial shift register plus the parallel code register and load strobe.
// Assumes shift_en and load_en are single-cycle events in the clk domain.
module sdf_capture #(
    parameter int CODE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    input  logic              load_en,
    output logic [CODE_W-1:0] shift_word,
    output logic [CODE_W-1:0] code_q,
    output logic              load_pulse
);
    logic [CODE_W-1:0] shift_q;

    // Shift one bit in at the LSB; the oldest bit falls off the top
    always_ff @(posedge clk) begin
        if (!rst_n)        shift_q <= '0;
        else if (shift_en) shift_q <= {shift_q[CODE_W-2:0], bit_in};
    end

    // Copy the shift register into the code register on a frame end
    always_ff @(posedge clk) begin
        if (!rst_n)       code_q <= '0;
        else if (load_en) code_q <= shift_q;
    end

    // Single-cycle strobe aligned with the code update
    always_ff @(posedge clk) begin
        if (!rst_n) load_pulse <= 1'b0;
        else        load_pulse <= load_en;
    end

    assign shift_word = shift_q;
endmodule

// File: rtl/sdf_frontend.sv
// Module: top of the serial-loaded converter code register.
// Assumes clk is at least 4x the serial clock and the serial clock is still
// while select rises. Pins are asynchronous and get two synchroniser stages.
module sdf_frontend #(
    parameter int CODE_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n_pin,
    input  logic              sclk_pin,
    input  logic              sdata_pin,
    output logic [CODE_W-1:0] dac_code,
    output logic              code_load
);
    import sdf_pkg::*;

    localparam logic [1:0] EDGE_IDLE = {PIN_IDLE[PIN_SEL], PIN_IDLE[PIN_SCLK]};

    logic [PIN_CNT-1:0] pins_raw;
    logic [PIN_CNT-1:0] pins_s;
    logic [1:0]         edge_rise;
    logic               sel_sync;
    logic               sclk_rise;
    logic               sel_rise;
    logic [CODE_W-1:0]  shift_word;

    // Bundle the pins in package order
    always_comb begin
        pins_raw            = '0;
        pins_raw[PIN_SDATA] = sdata_pin;
        pins_raw[PIN_SCLK]  = sclk_pin;
        pins_raw[PIN_SEL]   = sel_n_pin;
    end

    sdf_sync #(.W(PIN_CNT), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pins_raw),
        .q       (pins_s)
    );

    sdf_edge #(.W(2), .RST_VAL(EDGE_IDLE)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level ({pins_s[PIN_SEL], pins_s[PIN_SCLK]}),
        .rise  (edge_rise)
    );

    assign sel_sync  = pins_s[PIN_SEL];
    assign sclk_rise = edge_rise[0];
    assign sel_rise  = edge_rise[1];

    sdf_capture #(.CODE_W(CODE_W)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en   (sclk_rise & ~sel_sync),
        .bit_in     (pins_s[PIN_SDATA]),
        .load_en    (sel_rise),
        .shift_word (shift_word),
        .code_q     (dac_code),
        .load_pulse (code_load)
    );
endmodule

// File: rtl/sdf_frontend_chk.sv
// Module: property checker for sdf_frontend, attached by bind.
// Assumes it observes the top's ports and its synchronised internal nets.
module sdf_frontend_chk #(
    parameter int CODE_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              code_load,
    input logic [CODE_W-1:0] dac_code,
    input logic              sel_rise,
    input logic              sel_sync,
    input logic [CODE_W-1:0] shift_word
);
    AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        code_load |=> !code_load); // R6
    AST_LOAD_FOLLOWS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        sel_rise |=> code_load); // R3
    AST_SHIFT_FROZEN_SEL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        sel_sync |=> $stable(shift_word)); // R2
    AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !code_load |-> $stable(dac_code)); // R8
    AST_CODE_ZERO_AT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dac_code == '0 && !code_load)); // R7
endmodule

bind sdf_frontend sdf_frontend_chk #(.CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .code_load  (code_load),
    .dac_code   (dac_code),
    .sel_rise   (sel_rise),
    .sel_sync   (sel_sync),
    .shift_word (shift_word)
);

// File: tb/tb_sdf_frontend.sv
module tb_sdf_frontend;
    localparam int CLK_P = 10;
    localparam int HALF  = 4;

    typedef struct packed {
        logic [7:0]  nbits;
        logic [31:0] word;
        logic [15:0] exp_w;
        logic [13:0] exp_n;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{8'd16, 32'h0000A5C3, 16'hA5C3, 14'h25C3},
        '{8'd16, 32'h0000FFFF, 16'hFFFF, 14'h3FFF},
        '{8'd16, 32'h00000001, 16'h0001, 14'h0001},
        '{8'd20, 32'h000F1234, 16'h1234, 14'h1234},
        '{8'd16, 32'h00008000, 16'h8000, 14'h0000},
        '{8'd24, 32'h00ABCDEF, 16'hCDEF, 14'h0DEF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdata = 1'b0;
    logic [15:0] code_w;
    logic [13:0] code_n;
    logic        load_w, load_n;
    int          total = 0;
    int          bad = 0;
    int          cnt_w = 0;
    int          cnt_n = 0;

    always #(CLK_P/2) clk = ~clk;

    sdf_frontend #(.CODE_W(16)) dut (
        .clk(clk), .rst_n(rst_n), .sel_n_pin(sel_n), .sclk_pin(sclk),
        .sdata_pin(sdata), .dac_code(code_w), .code_load(load_w)
    );

    sdf_frontend #(.CODE_W(14)) dut_narrow (
        .clk(clk), .rst_n(rst_n), .sel_n_pin(sel_n), .sclk_pin(sclk),
        .sdata_pin(sdata), .dac_code(code_n), .code_load(load_n)
    );

    // Count load strobes seen on each instance
    always @(posedge clk) begin
        if (load_w) cnt_w <= cnt_w + 1;
        if (load_n) cnt_n <= cnt_n + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        sdata = b;
        wait_clk(HALF);
        sclk = 1'b1;
        wait_clk(HALF);
        sclk = 1'b0;
    endtask

    task automatic frame(input int nbits, input logic [31:0] word);
        sel_n = 1'b0;
        wait_clk(HALF);
        for (int i = nbits - 1; i >= 0; i--) send_bit(word[i]);
        wait_clk(HALF);
        sel_n = 1'b1;
        wait_clk(6);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int cw, cn;
        wait_clk(3);
        // R7: reset state
        chk("R7 code after reset", {16'd0, code_w}, 32'd0);
        chk("R7 strobe after reset", {31'd0, load_w}, 32'd0);
        rst_n = 1'b1;
        wait_clk(4);

        // R1 R4 R5 R6: vector walk
        for (int v = 0; v < NVEC; v++) begin
            cw = cnt_w; cn = cnt_n;
            frame(int'(VECS[v].nbits), VECS[v].word);
            chk((VECS[v].nbits > 16) ? "R4 wide code" : "R1 code", {16'd0, code_w}, {16'd0, VECS[v].exp_w});
            chk("R5 narrow code", {18'd0, code_n}, {18'd0, VECS[v].exp_n});
            chk("R6 one strobe", cnt_w - cw, 1);
            chk("R6 one strobe narrow", cnt_n - cn, 1);
        end

        // R6: short frame merges with old shift contents
        cw = cnt_w;
        frame(4, 32'hA);
        chk("R6 short frame", {16'd0, code_w}, 32'h0000DEFA);
        chk("R6 short frame narrow", {18'd0, code_n}, 32'h00001EFA);
        chk("R6 short strobe", cnt_w - cw, 1);

        // R2 R8: clocks with select high change nothing
        cw = cnt_w;
        for (int k = 0; k < 3; k++) send_bit(1'b1);
        wait_clk(6);
        chk("R8 code held", {16'd0, code_w}, 32'h0000DEFA);
        chk("R8 no strobe", cnt_w - cw, 0);
        frame(0, 32'd0);
        chk("R2 shift untouched", {16'd0, code_w}, 32'h0000DEFA);
        chk("R2 shift untouched narrow", {18'd0, code_n}, 32'h00001EFA);

        // R3: exact load latency of three system edges
        sel_n = 1'b0;
        wait_clk(HALF);
        for (int i = 15; i >= 0; i--) send_bit(logic'((16'h3C5A >> i) & 1));
        wait_clk(HALF);
        sel_n = 1'b1;
        wait_clk(2);
        chk("R3 not yet loaded", {16'd0, code_w}, 32'h0000DEFA);
        wait_clk(1);
        chk("R3 loaded on third edge", {16'd0, code_w}, 32'h00003C5A);
        chk("R3 strobe on third edge", {31'd0, load_w}, 32'd1);
        wait_clk(1);
        chk("R6 strobe single cycle", {31'd0, load_w}, 32'd0);

        // R7: mid-run reset clears code and shift register
        wait_clk(4);
        rst_n = 1'b0;
        wait_clk(3);
        chk("R7 code cleared", {16'd0, code_w}, 32'd0);
        rst_n = 1'b1;
        wait_clk(4);
        frame(0, 32'd0);
        chk("R7 shift cleared", {16'd0, code_w}, 32'd0);
        chk("R7 shift cleared narrow", {18'd0, code_n}, 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule